// File: doc/BRIEF.md
# Sector-Timed Recirculating Loop Memory

This block models the access timing of a rotating store. Storage is built as a set of word loops that move past a single head position. A free-running bit counter divides time into word slots of 27 bit times. Each slot holds 24 data bits followed by 3 gap bits. A 7-bit sector counter steps once per slot and names the word that is under the head. Each main channel has 128 sectors. Four short loops hold 1, 4, 8 and 16 words, so a word in a short loop passes the head again after that many word times.

A requester gives a channel code, a sector address, a read/write flag and, for writes, a 24-bit word, all in one cycle. The block stays busy until the addressed word reaches the head. It then streams the word out one bit per clock, least significant bit first. On a write it replaces the word bit by bit during that same pass. A read leaves the stored word unchanged. Access latency therefore depends on where the sector counter stands and on the length of the loop. It is not a fixed number of cycles.

Top module: `sector_loop_mem`

## Requirements
- R1: After reset, busy, rd_valid and done are 0, head_sector is 0, word_start is 1, and every stored word reads as zero.
- R2: word_start is high for one cycle in every 27. head_sector steps by one only in a cycle where word_start is high, and it wraps from 127 to 0.
- R3: A request is accepted on a clock edge where req_valid is 1, busy is 0 and the channel code is valid. busy is 1 from the next cycle until the transfer ends, and rd_valid stays 0 while the block waits.
- R4: The transfer starts at the first cycle in which word_start is 1 and the head matches the address. From the following cycle, rd_valid is 1 for 24 consecutive cycles, and rd_bit carries the stored word least significant bit first.
- R5: done is 1 for exactly one cycle, together with the 24th data bit. In that cycle busy is already 0, and rd_valid is 0 in the cycle after done.
- R6: A read does not change the stored word. Two reads of the same word return the same value.
- R7: A write (req_write=1) stores req_wdata into the addressed word and returns the word's previous contents on rd_bit. No other word in any channel changes.
- R8: Channel codes 0 and 1 select the main channels. Codes 2, 3, 4 and 5 select the loops of 1, 4, 8 and 16 words. For a loop of length L, the word used is address mod L, and it is reached when head_sector mod L equals address mod L.
- R9: The wait before a transfer is never longer than L word times for a loop of length L, or 128 word times for a main channel.
- R10: A request made while busy is 1, or one with channel code 6 or 7, is ignored. It does not raise busy and does not change any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | 3 | Channel code (main channels, then loops of 1/4/8/16) |
| req_addr | input | 7 | Sector address |
| req_wdata | input | 24 | Word to store on a write |
| busy | output | 1 | Request pending or in transfer |
| rd_valid | output | 1 | rd_bit carries a data bit |
| rd_bit | output | 1 | Serial word, LSB first |
| done | output | 1 | End-of-word pulse |
| head_sector | output | 7 | Sector currently under the head |
| word_start | output | 1 | First bit time of a word slot |

## Verification
The main function is exercised in four ways. Writes followed by reads of the same main sector show that data lands in the right place and that reads are non-destructive. A write to the other main channel at the same sector shows that the channels are kept apart. Writes and reads on the short loops, with addresses at or above the loop length, show that the address is reduced modulo the loop length (so two aliased addresses hit one word) and that the wait stays within the loop length. Requests made mid-transfer, and requests with invalid channel codes, separate real acceptance from requests that must be ignored. Every transfer is also timed against the head position to check when it starts.

// File: rtl/slm_pkg.sv
package slm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } slm_state_e;

    localparam int NUM_LOOPS = 4;

    // Length of short loop k: 1, 4, 8, 16 words.
    function automatic int loop_len(input int k);
        return (k == 0) ? 1 : (1 << (k + 1));
    endfunction

endpackage

// File: rtl/slm_sector_timer.sv
module slm_sector_timer #(
    parameter int SLOT_BITS = 27,
    parameter int SECTORS   = 128,
    parameter int BIT_W     = $clog2(SLOT_BITS),
    parameter int SECT_W    = $clog2(SECTORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [BIT_W-1:0]  bit_pos,
    output logic [SECT_W-1:0] sector,
    output logic              word_start
);

    typedef struct packed {
        logic [BIT_W-1:0]  bit_pos;
        logic [SECT_W-1:0] sect;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.bit_pos == BIT_W'(SLOT_BITS - 1)) begin
            tm_d.bit_pos = '0;
            if (tm_q.sect == SECT_W'(SECTORS - 1)) begin
                tm_d.sect = '0;
            end else begin
                tm_d.sect = tm_q.sect + 1'b1;
            end
        end else begin
            tm_d.bit_pos = tm_q.bit_pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign bit_pos    = tm_q.bit_pos;
    assign sector     = tm_q.sect;
    assign word_start = (tm_q.bit_pos == '0);

endmodule

// File: rtl/slm_loop_store.sv
module slm_loop_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 24,
    parameter int SECT_W = 7,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SECT_W-1:0] head,
    input  logic              wr_en,
    input  logic [BIT_W-1:0]  wr_pos,
    input  logic              wr_bit,
    output logic [DATA_W-1:0] head_word
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              unused_head;

    // The word under the head is the sector count modulo the loop depth.
    if (DEPTH > 1) begin : g_multi
        assign idx = head[IDX_W-1:0];
    end else begin : g_single
        assign idx = '0;
    end

    assign unused_head = ^head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[idx][wr_pos] <= wr_bit;
        end
    end

    assign head_word = mem[idx];

endmodule

// File: rtl/slm_access_ctrl.sv
module slm_access_ctrl
    import slm_pkg::*;
#(
    parameter int NUM_MAIN = 2,
    parameter int NUM_CH   = NUM_MAIN + NUM_LOOPS,
    parameter int CHAN_W   = $clog2(NUM_CH),
    parameter int SECT_W   = 7,
    parameter int BIT_W    = 5,
    parameter int DATA_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [SECT_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BIT_W-1:0]  bit_pos,
    input  logic [SECT_W-1:0] sector,
    input  logic [DATA_W-1:0] sel_word,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              wr_en,
    output logic [BIT_W-1:0]  wr_pos,
    output logic              wr_bit,
    output logic              busy,
    output logic              rd_valid,
    output logic              rd_bit,
    output logic              done
);

    typedef struct packed {
        slm_state_e        st;
        logic              wr;
        logic [CHAN_W-1:0] chan;
        logic [SECT_W-1:0] addr;
        logic [SECT_W-1:0] mask;
        logic [DATA_W-1:0] wdata;
        logic              rd_valid;
        logic              rd_bit;
        logic              done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  active;
    logic  hit;

    function automatic logic [SECT_W-1:0] mask_of(input logic [CHAN_W-1:0] c);
        if (int'(c) < NUM_MAIN) begin
            return '1;
        end
        return SECT_W'(loop_len(int'(c) - NUM_MAIN) - 1);
    endfunction

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        ctl_d.rd_bit   = 1'b0;
        ctl_d.done     = 1'b0;
        wr_en          = 1'b0;
        wr_pos         = bit_pos;
        wr_bit         = ctl_q.wdata[bit_pos];

        hit    = (((sector ^ ctl_q.addr) & ctl_q.mask) == '0);
        active = ((ctl_q.st == ST_WAIT) && (bit_pos == '0) && hit)
                 || (ctl_q.st == ST_XFER);

        if (ctl_q.st == ST_IDLE) begin
            if (req_valid && (int'(req_chan) < NUM_CH)) begin
                ctl_d.st    = ST_WAIT;
                ctl_d.wr    = req_write;
                ctl_d.chan  = req_chan;
                ctl_d.addr  = req_addr;
                ctl_d.mask  = mask_of(req_chan);
                ctl_d.wdata = req_wdata;
            end
        end

        if (active) begin
            ctl_d.rd_valid = 1'b1;
            ctl_d.rd_bit   = sel_word[bit_pos];
            wr_en          = ctl_q.wr;
            if (bit_pos == BIT_W'(DATA_W - 1)) begin
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
            end else begin
                ctl_d.st   = ST_XFER;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign chan_sel = ctl_q.chan;
    assign busy     = (ctl_q.st != ST_IDLE);
    assign rd_valid = ctl_q.rd_valid;
    assign rd_bit   = ctl_q.rd_bit;
    assign done     = ctl_q.done;

endmodule

// File: rtl/sector_loop_mem.sv
module sector_loop_mem
    import slm_pkg::*;
#(
    parameter int NUM_MAIN = 2,
    parameter int DATA_W   = 24,
    parameter int GAP_BITS = 3,
    parameter int SECTORS  = 128,
    parameter int NUM_CH   = NUM_MAIN + NUM_LOOPS,
    parameter int CHAN_W   = $clog2(NUM_CH),
    parameter int SECT_W   = $clog2(SECTORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [SECT_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic              rd_bit,
    output logic              done,
    output logic [SECT_W-1:0] head_sector,
    output logic              word_start
);

    localparam int SLOT_BITS = DATA_W + GAP_BITS;
    localparam int BIT_W     = $clog2(SLOT_BITS);

    logic [BIT_W-1:0]  bit_pos;
    logic [SECT_W-1:0] sector;
    logic [CHAN_W-1:0] chan_sel;
    logic              wr_en;
    logic [BIT_W-1:0]  wr_pos;
    logic              wr_bit;
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] words [NUM_CH];

    slm_sector_timer #(
        .SLOT_BITS (SLOT_BITS),
        .SECTORS   (SECTORS),
        .BIT_W     (BIT_W),
        .SECT_W    (SECT_W)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_pos    (bit_pos),
        .sector     (sector),
        .word_start (word_start)
    );

    slm_access_ctrl #(
        .NUM_MAIN (NUM_MAIN),
        .NUM_CH   (NUM_CH),
        .CHAN_W   (CHAN_W),
        .SECT_W   (SECT_W),
        .BIT_W    (BIT_W),
        .DATA_W   (DATA_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_chan  (req_chan),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bit_pos   (bit_pos),
        .sector    (sector),
        .sel_word  (sel_word),
        .chan_sel  (chan_sel),
        .wr_en     (wr_en),
        .wr_pos    (wr_pos),
        .wr_bit    (wr_bit),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_bit    (rd_bit),
        .done      (done)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_store
        localparam int DEPTH = (g < NUM_MAIN) ? SECTORS : loop_len(g - NUM_MAIN);
        slm_loop_store #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W),
            .SECT_W (SECT_W),
            .BIT_W  (BIT_W)
        ) i_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .head      (sector),
            .wr_en     (wr_en && (chan_sel == CHAN_W'(g))),
            .wr_pos    (wr_pos),
            .wr_bit    (wr_bit),
            .head_word (words[g])
        );
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan_sel == CHAN_W'(i)) begin
                sel_word = words[i];
            end
        end
    end

    assign head_sector = sector;

endmodule

// File: rtl/slm_checker.sv
module slm_checker #(
    parameter int SECT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rd_valid,
    input logic              done,
    input logic [SECT_W-1:0] head_sector,
    input logic              word_start
);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && rd_valid));

    assert_done_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rd_valid);

    assert_data_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(busy));

    assert_no_data_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rd_valid);

    assert_head_steps_at_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head_sector) |-> word_start);

    assert_slot_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |=> !word_start);

endmodule

bind sector_loop_mem slm_checker #(.SECT_W(SECT_W)) i_slm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .done        (done),
    .head_sector (head_sector),
    .word_start  (word_start)
);

// File: tb/test_sector_loop_mem.sv
module test_sector_loop_mem;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_chan = '0;
    logic [6:0]  req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic        busy, rd_valid, rd_bit, done, word_start;
    logic [6:0]  head_sector;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sector_loop_mem i_sector_loop_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_chan    (req_chan),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .busy        (busy),
        .rd_valid    (rd_valid),
        .rd_bit      (rd_bit),
        .done        (done),
        .head_sector (head_sector),
        .word_start  (word_start)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  ch;
        logic [6:0]  ad;
        logic [23:0] wd;
        logic [23:0] ex;
    } vec_t;

    // ex = word returned on rd_bit (old contents on a write)
    localparam vec_t VEC [14] = '{
        '{1'b1, 3'd0, 7'd5,   24'hA5A5A5, 24'h000000},
        '{1'b0, 3'd0, 7'd5,   24'h000000, 24'hA5A5A5},
        '{1'b0, 3'd0, 7'd5,   24'h000000, 24'hA5A5A5},
        '{1'b1, 3'd1, 7'd5,   24'h123456, 24'h000000},
        '{1'b0, 3'd0, 7'd5,   24'h000000, 24'hA5A5A5},
        '{1'b1, 3'd2, 7'd0,   24'hFFFFFF, 24'h000000},
        '{1'b0, 3'd2, 7'd3,   24'h000000, 24'hFFFFFF},
        '{1'b1, 3'd3, 7'd2,   24'h0F0F0F, 24'h000000},
        '{1'b1, 3'd3, 7'd6,   24'h00FF00, 24'h0F0F0F},
        '{1'b0, 3'd3, 7'd2,   24'h000000, 24'h00FF00},
        '{1'b1, 3'd5, 7'd15,  24'h800001, 24'h000000},
        '{1'b0, 3'd4, 7'd7,   24'h000000, 24'h000000},
        '{1'b0, 3'd5, 7'd31,  24'h000000, 24'h800001},
        '{1'b0, 3'd1, 7'd5,   24'h000000, 24'h123456}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] mask_of(input logic [2:0] ch);
        case (ch)
            3'd2:    return 7'd0;
            3'd3:    return 7'd3;
            3'd4:    return 7'd7;
            3'd5:    return 7'd15;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic int len_of(input logic [2:0] ch);
        return int'(mask_of(ch)) + 1;
    endfunction

    // One access; inj drives an extra request while busy (R10).
    task automatic do_op(input logic wr, input logic [2:0] ch, input logic [6:0] ad,
                         input logic [23:0] wd, input logic [23:0] ex, input bit inj);
        int          miss = 0;
        int          it = 0;
        bit          wait_ok = 1'b1;
        bit          valid_ok = 1'b1;
        bit          done_ok = 1'b1;
        logic [23:0] got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_chan = ch;
        req_addr = ad; req_wdata = wd;
        @(negedge clk);
        while (1) begin
            if (inj && it == 0) begin
                req_valid = 1'b1; req_write = 1'b1; req_chan = 3'd1;
                req_addr = 7'd3; req_wdata = 24'h222222;
            end else begin
                req_valid = 1'b0;
            end
            if (!busy || rd_valid) wait_ok = 1'b0;
            if (word_start && (((head_sector ^ ad) & mask_of(ch)) == 7'd0)) break;
            if (word_start) miss++;
            it++;
            @(negedge clk);
        end
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (!rd_valid) valid_ok = 1'b0;
            got[i] = rd_bit;
            if (i == 23) begin
                if (!done || busy) done_ok = 1'b0;
            end else begin
                if (done || !busy) done_ok = 1'b0;
            end
        end
        chk(wait_ok, "R3 busy high and no data while waiting", {31'd0, wait_ok}, 32'd1);
        chk(miss < len_of(ch), "R9 wait bound in word times", miss, len_of(ch));
        chk(valid_ok, "R4 rd_valid for 24 bits", {31'd0, valid_ok}, 32'd1);
        chk(got == ex, "R4/R6/R7/R8 serial word", {8'd0, got}, {8'd0, ex});
        chk(done_ok, "R5 done with last bit", {31'd0, done_ok}, 32'd1);
        @(negedge clk);
        chk(!rd_valid && !busy, "R5 idle after done", {30'd0, rd_valid, busy}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        bit quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!busy && !rd_valid && !done, "R1 outputs idle", {29'd0, busy, rd_valid, done}, 32'd0);
        chk(head_sector == 7'd0 && word_start, "R1 head at 0", {24'd0, head_sector, word_start}, 32'd1);

        // R2 slot period
        @(negedge clk);
        n = 1;
        while (!word_start) begin
            @(negedge clk);
            n++;
        end
        chk(n == 27, "R2 slot period", n, 27);
        chk(head_sector == 7'd1, "R2 head step", head_sector, 1);

        // R1 stored words read as zero (main channel 1, sector 9)
        do_op(1'b0, 3'd1, 7'd9, 24'h0, 24'h0, 1'b0);

        // Table walk: R4 R6 R7 R8
        for (int v = 0; v < 14; v++) begin
            do_op(VEC[v].wr, VEC[v].ch, VEC[v].ad, VEC[v].wd, VEC[v].ex, 1'b0);
        end

        // R10 request while busy is ignored
        do_op(1'b1, 3'd0, 7'd100, 24'h111111, 24'h000000, 1'b1);
        chk(!busy, "R10 no busy after ignored request", {31'd0, busy}, 32'd0);
        do_op(1'b0, 3'd1, 7'd3, 24'h0, 24'h000000, 1'b0);
        do_op(1'b0, 3'd0, 7'd100, 24'h0, 24'h111111, 1'b0);

        // R10 invalid channel codes ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_chan = 3'd7; req_addr = 7'd5;
        req_wdata = 24'hDEAD00;
        @(negedge clk);
        req_chan = 3'd6;
        @(negedge clk);
        req_valid = 1'b0;
        quiet = 1'b1;
        repeat (60) begin
            if (busy || rd_valid) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R10 invalid channel ignored", {31'd0, quiet}, 32'd1);
        do_op(1'b0, 3'd0, 7'd5, 24'h0, 24'hA5A5A5, 1'b0);

        // R2 wrap 127 -> 0
        while (!(word_start && head_sector == 7'd127)) @(negedge clk);
        repeat (27) @(negedge clk);
        chk(word_start && head_sector == 7'd0, "R2 wrap to zero", {24'd0, head_sector, word_start}, 32'd1);

        // R9 main channel wait bound, address just behind head
        do_op(1'b0, 3'd0, 7'd0, 24'h0, 24'h0, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule